// File: doc/BRIEF.md
# Shared Capture/Compare Timebase Counter

This block is the single free-running up-counter that a group of five capture/compare channels read as their common time reference. The count is held as a low half and a high half. Software can load each half on its own write port. The counter advances on one of four event sources, chosen by a 2-bit select: a divide-by-12 oscillator prescale, a divide-by-4 oscillator prescale, a one-cycle overflow pulse from a neighbouring timer, or falling edges on an external count pin.

A run enable gates every advance. A hold enable can also freeze the count while the device is idle. When the count wraps from all ones to zero, a sticky overflow flag is set, and it stays set until software clears it. The `tick` output pulses in each cycle that actually advances the count, so that the channels can qualify their compare matches on it.

The external pin passes through two synchronizer flops. It is then sampled once per divide-by-12 period, and one count is taken when a sample is low and the sample before it was high. A clean external clock therefore counts at up to one twenty-fourth of the oscillator rate. The capture, compare and PWM channels themselves are not part of this block.

Top module: `capture_timebase`

## Requirements
- R1: While `rst` is high at a clock edge, `count` and `ovf` are cleared to zero. The synchronizer and sample flops are set to one, so no false pin edge is seen after reset.
- R2: With `src_sel` = 0, the count advances once every DIV_SLOW (12) clocks. The first advance comes on the 12th rising edge after reset is released.
- R3: With `src_sel` = 1, the count advances once every DIV_FAST (4) clocks. The first advance comes on the 4th rising edge after reset is released.
- R4: With `src_sel` = 2, the count advances by one at each clock edge where `t0_wrap` is high.
- R5: With `src_sel` = 3, the count advances once for each high-to-low change seen between two consecutive samples of the synchronized `ext_cnt`. Samples are taken once per DIV_SLOW clocks, so the pin can produce at most one count per 2×DIV_SLOW clocks however fast it toggles.
- R6: While `run_en` is low, the count does not change except by software writes.
- R7: While both `idle` and `idle_hold_en` are high, the count does not advance. With `idle` high and `idle_hold_en` low, it advances at the normal rate.
- R8: Each advance yields (count+1) mod 2^CNT_W. An advance from all ones sets `ovf`.
- R9: `ovf` stays set until a clock edge with `ovf_clr` high and no wrap. A wrap in the same cycle as `ovf_clr` leaves `ovf` set.
- R10: A write on `lo_we` or `hi_we` loads the selected half or halves from the matching data port. In that cycle any advance is dropped and `ovf` is not set.
- R11: `tick` is high exactly in the cycles whose following clock edge advances the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 2 | Event source: 0 slow prescale, 1 fast prescale, 2 timer pulse, 3 external pin |
| run_en | input | 1 | Count enable |
| idle | input | 1 | Device idle indication |
| idle_hold_en | input | 1 | Freeze the count while idle |
| t0_wrap | input | 1 | One-cycle overflow pulse from another timer |
| ext_cnt | input | 1 | Asynchronous external count pin |
| lo_we | input | 1 | Low-half write strobe |
| lo_wdata | input | CNT_W/2 | Low-half write data |
| hi_we | input | 1 | High-half write strobe |
| hi_wdata | input | CNT_W/2 | High-half write data |
| ovf_clr | input | 1 | Clear the overflow flag |
| count | output | CNT_W | Current count |
| ovf | output | 1 | Sticky wrap flag |
| tick | output | 1 | High in cycles that advance the count |

## Verification
The bench builds the block with CNT_W = 8, so each half is 4 bits wide. This lets it load every one of the 256 counter values, advance each by one, and compare the result and the overflow flag against arithmetic. The prescale divides keep their default values of 12 and 4, so exact advance counts over fixed windows from reset are predictable. A 4-clock toggle on the external pin is also applied, to show that the pin's count rate is limited.

// File: rtl/capture_timebase.sv
module capture_timebase #(
  parameter int CNT_W    = 16,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         src_sel,
  input  logic               run_en,
  input  logic               idle,
  input  logic               idle_hold_en,
  input  logic               t0_wrap,
  input  logic               ext_cnt,
  input  logic               lo_we,
  input  logic [CNT_W/2-1:0] lo_wdata,
  input  logic               hi_we,
  input  logic [CNT_W/2-1:0] hi_wdata,
  input  logic               ovf_clr,
  output logic [CNT_W-1:0]   count,
  output logic               ovf,
  output logic               tick
);
  localparam int HALF_W = CNT_W / 2;
  localparam int SLOW_W = $clog2(DIV_SLOW);
  localparam int FAST_W = $clog2(DIV_FAST);

  logic [SLOW_W-1:0] slow_cnt;
  logic [FAST_W-1:0] fast_cnt;
  logic slow_hit, fast_hit;
  logic ext_s1, ext_s2, ext_prev, ext_fall;
  logic src_evt, any_wr;

  assign slow_hit = (slow_cnt == SLOW_W'(DIV_SLOW - 1));
  assign fast_hit = (fast_cnt == FAST_W'(DIV_FAST - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      slow_cnt <= '0;
      fast_cnt <= '0;
    end else begin
      slow_cnt <= slow_hit ? '0 : slow_cnt + SLOW_W'(1);
      fast_cnt <= fast_hit ? '0 : fast_cnt + FAST_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_s1   <= 1'b1;
      ext_s2   <= 1'b1;
      ext_prev <= 1'b1;
    end else begin
      ext_s1 <= ext_cnt;
      ext_s2 <= ext_s1;
      if (slow_hit) ext_prev <= ext_s2;
    end
  end

  assign ext_fall = slow_hit & ext_prev & ~ext_s2;

  always_comb begin
    case (src_sel)
      2'd0:    src_evt = slow_hit;
      2'd1:    src_evt = fast_hit;
      2'd2:    src_evt = t0_wrap;
      default: src_evt = ext_fall;
    endcase
  end

  assign any_wr = lo_we | hi_we;
  assign tick   = run_en & ~(idle & idle_hold_en) & src_evt & ~any_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (any_wr) begin
      if (lo_we) count[HALF_W-1:0]     <= lo_wdata;
      if (hi_we) count[CNT_W-1:HALF_W] <= hi_wdata;
    end else if (tick) begin
      count <= count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                ovf <= 1'b0;
    else if (tick & &count) ovf <= 1'b1;
    else if (ovf_clr)       ovf <= 1'b0;
  end
endmodule

// File: rtl/capture_timebase_checks.sv
module capture_timebase_checks #(
  parameter int CNT_W = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               run_en,
  input logic               lo_we,
  input logic [CNT_W/2-1:0] lo_wdata,
  input logic               hi_we,
  input logic [CNT_W/2-1:0] hi_wdata,
  input logic               ovf_clr,
  input logic [CNT_W-1:0]   count,
  input logic               ovf,
  input logic               tick
);
  localparam int HALF_W = CNT_W / 2;

  p_lo_load_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(lo_we) |-> count[HALF_W-1:0] == $past(lo_wdata));

  p_hi_load_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(hi_we) |-> count[CNT_W-1:HALF_W] == $past(hi_wdata));

  p_stopped_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(run_en) && !$past(lo_we) && !$past(hi_we) |-> $stable(count));

  p_tick_adv_r11: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(tick) |-> count == CNT_W'($past(count) + CNT_W'(1)));

  p_wrap_flag_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(tick) && $past(&count) |-> ovf);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(ovf) && !$past(ovf_clr) |-> ovf);
endmodule

bind capture_timebase capture_timebase_checks #(.CNT_W(CNT_W)) u_checks (
  .clk(clk), .rst(rst), .run_en(run_en),
  .lo_we(lo_we), .lo_wdata(lo_wdata), .hi_we(hi_we), .hi_wdata(hi_wdata),
  .ovf_clr(ovf_clr), .count(count), .ovf(ovf), .tick(tick)
);

// File: tb/capture_timebase_test.sv
`timescale 1ns/100ps
module capture_timebase_test;
  localparam int W = 8;
  localparam int H = W / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] src_sel = 2'd0;
  logic run_en = 1'b0, idle = 1'b0, idle_hold_en = 1'b0;
  logic t0_wrap = 1'b0, ext_cnt = 1'b1;
  logic lo_we = 1'b0, hi_we = 1'b0, ovf_clr = 1'b0;
  logic [H-1:0] lo_wdata = '0, hi_wdata = '0;
  logic [W-1:0] count;
  logic ovf, tick;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  capture_timebase #(.CNT_W(W), .DIV_SLOW(12), .DIV_FAST(4)) uut (
    .clk(clk), .rst(rst), .src_sel(src_sel), .run_en(run_en), .idle(idle),
    .idle_hold_en(idle_hold_en), .t0_wrap(t0_wrap), .ext_cnt(ext_cnt),
    .lo_we(lo_we), .lo_wdata(lo_wdata), .hi_we(hi_we), .hi_wdata(hi_wdata),
    .ovf_clr(ovf_clr), .count(count), .ovf(ovf), .tick(tick)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel, input logic run);
    @(negedge clk);
    rst = 1'b1; src_sel = sel; run_en = run;
    idle = 1'b0; idle_hold_en = 1'b0; t0_wrap = 1'b0; ext_cnt = 1'b1;
    lo_we = 1'b0; hi_we = 1'b0; ovf_clr = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load(input int v);
    lo_we = 1'b1; hi_we = 1'b1;
    lo_wdata = H'(v); hi_wdata = H'(v >> H);
    @(negedge clk);
    lo_we = 1'b0; hi_we = 1'b0;
  endtask

  task automatic pulse_t0;
    t0_wrap = 1'b1;
    @(negedge clk);
    t0_wrap = 1'b0;
  endtask

  initial begin
    #900000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int ticks;
    do_reset(2'd0, 1'b1);
    check("R1 count", int'(count), 0);
    check("R1 ovf", int'(ovf), 0);

    repeat (11) @(negedge clk);
    check("R2 before 12th edge", int'(count), 0);
    repeat (109) @(negedge clk);
    check("R2 slow 120", int'(count), 10);

    do_reset(2'd1, 1'b1);
    ticks = 0;
    for (int i = 0; i < 120; i++) begin
      if (tick) ticks++;
      @(negedge clk);
    end
    check("R3 fast 120", int'(count), 30);
    check("R11 tick pulses", ticks, 30);

    do_reset(2'd1, 1'b0);
    repeat (120) @(negedge clk);
    check("R6 run off", int'(count), 0);

    do_reset(2'd1, 1'b1);
    idle = 1'b1; idle_hold_en = 1'b1;
    repeat (120) @(negedge clk);
    check("R7 idle held", int'(count), 0);

    do_reset(2'd1, 1'b1);
    idle = 1'b1; idle_hold_en = 1'b0;
    repeat (120) @(negedge clk);
    check("R7 idle running", int'(count), 30);

    do_reset(2'd2, 1'b1);
    for (int i = 0; i < 7; i++) begin
      pulse_t0();
      @(negedge clk);
    end
    check("R4 timer pulses", int'(count), 7);

    do_reset(2'd3, 1'b1);
    repeat (30) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      ext_cnt = 1'b0; repeat (12) @(negedge clk);
      ext_cnt = 1'b1; repeat (12) @(negedge clk);
    end
    repeat (40) @(negedge clk);
    check("R5 slow pin falls", int'(count), 5);

    do_reset(2'd3, 1'b1);
    for (int i = 0; i < 60; i++) begin
      ext_cnt = 1'b0; repeat (2) @(negedge clk);
      ext_cnt = 1'b1; repeat (2) @(negedge clk);
    end
    repeat (30) @(negedge clk);
    check("R5 fast pin limited", int'(count <= 11), 1);

    do_reset(2'd2, 1'b1);
    for (int v = 0; v < (1 << W); v++) begin
      load(v);
      check("R10 load", int'(count), v);
      pulse_t0();
      check("R8 advance", int'(count), (v + 1) % (1 << W));
      check("R8 wrap flag", int'(ovf), (v == (1 << W) - 1) ? 1 : 0);
      ovf_clr = 1'b1; @(negedge clk); ovf_clr = 1'b0;
    end

    load((1 << W) - 1);
    pulse_t0();
    pulse_t0(); pulse_t0();
    check("R9 sticky", int'(ovf), 1);
    load((1 << W) - 1);
    t0_wrap = 1'b1; ovf_clr = 1'b1;
    @(negedge clk);
    t0_wrap = 1'b0;
    check("R9 set beats clear", int'(ovf), 1);
    @(negedge clk);
    ovf_clr = 1'b0;
    check("R9 cleared", int'(ovf), 0);

    load(8'h35);
    lo_we = 1'b1; lo_wdata = 4'hA; t0_wrap = 1'b1;
    @(negedge clk);
    lo_we = 1'b0; t0_wrap = 1'b0;
    check("R10 write over advance", int'(count), 8'h3A);
    load((1 << W) - 1);
    hi_we = 1'b1; hi_wdata = 4'hF; t0_wrap = 1'b1;
    @(negedge clk);
    hi_we = 1'b0; t0_wrap = 1'b0;
    check("R10 no wrap on write", int'(count), (1 << W) - 1);
    check("R10 no flag on write", int'(ovf), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule